// File: doc/BRIEF.md
# AES3 Channel Status Bit Sequencer

This block produces the side bits that an AES3 transmitter attaches to every subframe: the channel status bit, the validity bit and the user bit. It watches the left/right word clock and treats each change of that clock as the start of a new subframe. A high word clock marks the first subframe of a frame and a low word clock marks the second. The block counts frames through a 192-frame status block. It also reports, or accepts, the start of each status block on a single line that can face either way.

The status bits come from one of two sources. In strapped mode, four static control inputs build a fixed status word that is sent least significant bit first, one bit per frame. In serial mode, the copy input becomes a live data line that supplies one status bit per subframe. Validity and user bits are taken from their inputs at every subframe boundary in both modes. Line coding, preambles and audio sample transport are handled downstream.

Top module: `aes_cstat_seq`

## Requirements
- R1: While `rst_n` is low, `sf_stb`, `c_bit`, `v_bit`, `u_bit` and `blk_out` are all 0.
- R2: Each change of `lrck` produces exactly one single-cycle `sf_stb` pulse. It is visible in the cycle after the third rising `clk` edge that follows the change. `c_bit`, `v_bit`, `u_bit` and `blk_out` change only together with that pulse.
- R3: At each strobe, `v_bit` and `u_bit` equal the `v_in` and `u_in` levels that were present at the `lrck` change.
- R4: A subframe begun by `lrck` going high is the first of a new frame. The frame index runs 0 to 191 and wraps to 0. The first frame after reset is 0. `blk_out` is 1 only in the first subframe of frame 0, and in no other subframe.
- R5: `blk_oe` equals `blk_dir`. When it is 1 the block drives the block-start pad; when it is 0 the pad is an input.
- R6: With `blk_dir` = 0, a high level on `blk_in` lasting at least 3 `clk` cycles makes the next subframe frame 0 with `blk_out` = 1, whichever half it is. Frame counting then continues from 0.
- R7: With `blk_dir` = 0, a high pulse on `blk_in` of only 2 `clk` cycles leaves the frame sequence unchanged.
- R8: With `blk_dir` = 1, `blk_in` has no effect on the frame sequence.
- R9: With `mode_b` = 1, `c_bit` equals the `copy_c` level present at the `lrck` change, for every subframe.
- R10: With `mode_b` = 0, both subframes of frame k carry status bit k. The assigned bits are: bit 0 = `copy_c` AND `orig` (professional); bit 1 = `audio` (non-audio flag); bit 2 = `copy_c` AND NOT `orig` (copyright); bit 15 = `orig` AND NOT `copy_c` (generation). Every other bit is 0.
- R11: With `mode_b` = 0, the emphasis field in bits 3, 4 and 5 is 1, 0, 0 when `emph_n` is 0 (50/15 us pre-emphasis). It is 0, 0, 0 when `emph_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Left/right word clock, asynchronous to `clk` |
| mode_b | input | 1 | 0: status word from control inputs; 1: serial status bits on `copy_c` |
| copy_c | input | 1 | Copy control (mode A) or serial status data (mode B) |
| orig | input | 1 | Origin control (mode A) |
| emph_n | input | 1 | Active-low pre-emphasis control (mode A) |
| audio | input | 1 | Non-audio flag control (mode A) |
| v_in | input | 1 | Validity bit source |
| u_in | input | 1 | User bit source |
| blk_dir | input | 1 | Block-start pad direction, 1 = output |
| blk_in | input | 1 | Block-start pad input level |
| sf_stb | output | 1 | One-cycle pulse at each subframe start |
| c_bit | output | 1 | Channel status bit of the current subframe |
| v_bit | output | 1 | Validity bit of the current subframe |
| u_bit | output | 1 | User bit of the current subframe |
| blk_out | output | 1 | Block-start level to drive onto the pad |
| blk_oe | output | 1 | Pad output enable |

## Verification
The bench attacks block-start qualification at its edge. A 2-cycle pulse must be rejected and a 3-cycle pulse must force frame 0. An off-by-one in the qualifier would either resynchronize on glitches or miss a legal strobe. It runs more than a full block with the pad as an output to confirm wrap at 191 and that the strobe marks only the first half of frame 0. A counter that wrapped at 192, or a strobe that stayed high for both halves, shows up there. All sixteen control combinations are swept in strapped mode over the first 24 frames, which catches swapped copyright and generation bits, an emphasis code sent in the wrong order, or a status bit that differs between the two halves of a frame.

// File: rtl/aes_cs_pkg.sv
`timescale 1ns/1ps
package aes_cs_pkg;

    // Strapped-mode status word: bit at position idx of the block.
    function automatic logic strap_bit(input int unsigned idx,
                                       input logic copy_c,
                                       input logic orig,
                                       input logic emph_n,
                                       input logic audio);
        logic b;
        case (idx)
            0:       b = copy_c & orig;      // professional
            1:       b = audio;              // non-audio flag
            2:       b = copy_c & ~orig;     // copyright
            3:       b = ~emph_n;            // emphasis field, first bit
            15:      b = orig & ~copy_c;     // generation
            default: b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cs_blk_qual.sv
`timescale 1ns/1ps
module cs_blk_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pin,
    input  logic take,
    output logic armed
);
    localparam int unsigned CW = $clog2(MIN_PULSE + 1);

    logic          pin_s;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          arm_d, arm_q;

    cs_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin),
        .dout (pin_s)
    );

    always_comb begin
        cnt_d = cnt_q;
        arm_d = arm_q;
        if (take) arm_d = 1'b0;
        if (!enable || !pin_s) begin
            cnt_d = '0;
        end else if (cnt_q < CW'(MIN_PULSE)) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CW'(MIN_PULSE - 1)) arm_d = 1'b1;
        end
        if (!enable) arm_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            arm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            arm_q <= arm_d;
        end
    end

    assign armed = arm_q;
endmodule

// File: rtl/aes_cstat_seq.sv
`timescale 1ns/1ps
module aes_cstat_seq #(
    parameter int unsigned FRAMES      = 192,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    input  logic mode_b,
    input  logic copy_c,
    input  logic orig,
    input  logic emph_n,
    input  logic audio,
    input  logic v_in,
    input  logic u_in,
    input  logic blk_dir,
    input  logic blk_in,
    output logic sf_stb,
    output logic c_bit,
    output logic v_bit,
    output logic u_bit,
    output logic blk_out,
    output logic blk_oe
);
    import aes_cs_pkg::*;

    localparam int unsigned FW = $clog2(FRAMES);

    typedef struct packed {
        logic [FW-1:0] frame;
        logic          prev_lr;
        logic          stb;
        logic          first;
        logic          c;
        logic          v;
        logic          u;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic          lr_s;
    logic          armed;
    logic          boundary;
    logic [FW-1:0] frame_n;

    cs_sync #(.STAGES(SYNC_STAGES)) i_lr_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lrck),
        .dout (lr_s)
    );

    cs_blk_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)) i_blk_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(~blk_dir),
        .pin   (blk_in),
        .take  (boundary),
        .armed (armed)
    );

    assign boundary = lr_s ^ st_q.prev_lr;

    always_comb begin
        st_d         = st_q;
        st_d.stb     = 1'b0;
        st_d.prev_lr = lr_s;
        frame_n      = st_q.frame;
        if (armed) begin
            frame_n = '0;
        end else if (lr_s) begin
            frame_n = (st_q.frame == FW'(FRAMES - 1)) ? '0 : st_q.frame + 1'b1;
        end
        if (boundary) begin
            st_d.frame = frame_n;
            st_d.stb   = 1'b1;
            st_d.first = armed | (lr_s & (frame_n == '0));
            st_d.v     = v_in;
            st_d.u     = u_in;
            st_d.c     = mode_b ? copy_c
                                : strap_bit(32'(frame_n), copy_c, orig, emph_n, audio);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{frame: FW'(FRAMES - 1), default: '0};
        else        st_q <= st_d;
    end

    assign sf_stb  = st_q.stb;
    assign c_bit   = st_q.c;
    assign v_bit   = st_q.v;
    assign u_bit   = st_q.u;
    assign blk_out = st_q.first;
    assign blk_oe  = blk_dir;
endmodule

// File: rtl/aes_cstat_seq_chk.sv
`timescale 1ns/1ps
module aes_cstat_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_b,
    input logic copy_c,
    input logic orig,
    input logic v_in,
    input logic u_in,
    input logic sf_stb,
    input logic c_bit,
    input logic v_bit,
    input logic u_bit,
    input logic blk_out
);
    // R3
    a_r3_valid_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        sf_stb |-> v_bit == $past(v_in));
    // R3
    a_r3_user_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        sf_stb |-> u_bit == $past(u_in));
    // R2
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_stb |-> ($stable(c_bit) && $stable(v_bit) && $stable(u_bit) && $stable(blk_out)));
    // R9
    a_r9_serial_c: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb && $past(mode_b)) |-> c_bit == $past(copy_c));
    // R10
    a_r10_frame0_pro: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_stb && blk_out && !$past(mode_b)) |-> c_bit == $past(copy_c && orig));
endmodule

bind aes_cstat_seq aes_cstat_seq_chk i_chk (.*);

// File: tb/test_aes_cstat_seq.sv
`timescale 1ns/1ps
module test_aes_cstat_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lrck = 1'b0, mode_b = 1'b0, copy_c = 1'b0, orig = 1'b0;
    logic emph_n = 1'b1, audio = 1'b0, v_in = 1'b0, u_in = 1'b0;
    logic blk_dir = 1'b1, blk_in = 1'b0;
    logic sf_stb, c_bit, v_bit, u_bit, blk_out, blk_oe;

    int checks = 0;
    int errors = 0;
    int exp_frame = 191;
    bit pend_force = 1'b0;

    always #2.5 clk = ~clk;

    aes_cstat_seq i_aes_cstat_seq (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ref_bit(input int k);
        case (k)
            0:  return copy_c & orig;
            1:  return audio;
            2:  return copy_c & ~orig;
            3:  return ~emph_n;
            15: return orig & ~copy_c;
            default: return 1'b0;
        endcase
    endfunction

    // one subframe: toggle lrck, check strobe and bits, optional blk_in pulse
    task automatic sub(input bit v, input bit u, input bit c, input int pulse, input string btag);
        bit exp_first;
        int seen;
        @(negedge clk);
        v_in = v; u_in = u;
        if (mode_b) copy_c = c;
        lrck = ~lrck;
        if (pend_force) begin
            exp_frame = 0; exp_first = 1'b1;
        end else if (lrck) begin
            exp_frame = (exp_frame + 1) % 192; exp_first = (exp_frame == 0);
        end else begin
            exp_first = 1'b0;
        end
        pend_force = 1'b0;
        seen = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (sf_stb && seen == 0) seen = k;
            if (seen != 0) break;
        end
        chk(seen == 3, "R2 strobe latency", seen, 3);
        chk(v_bit == v, "R3 validity", v_bit, v);
        chk(u_bit == u, "R3 user", u_bit, u);
        chk(blk_out == exp_first, btag, blk_out, exp_first);
        if (mode_b) chk(c_bit == c, "R9 serial C", c_bit, c);
        else        chk(c_bit == ref_bit(exp_frame), "R10 R11 strap C", c_bit, ref_bit(exp_frame));
        @(negedge clk);
        chk(sf_stb == 1'b0, "R2 single pulse", sf_stb, 0);
        if (pulse > 0) begin
            blk_in = 1'b1;
            repeat (pulse) @(negedge clk);
            blk_in = 1'b0;
            if (!blk_dir && pulse >= 3) pend_force = 1'b1;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(sf_stb == 0, "R1 stb", sf_stb, 0);
        chk(c_bit == 0 && v_bit == 0 && u_bit == 0, "R1 bits", {c_bit, v_bit, u_bit}, 0);
        chk(blk_out == 0, "R1 blk_out", blk_out, 0);
        chk(blk_oe == 1, "R5 oe high", blk_oe, 1);
        blk_dir = 1'b0; #1;
        chk(blk_oe == 0, "R5 oe low", blk_oe, 0);
        blk_dir = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic t_vu();
        for (int i = 0; i < 8; i++) sub(i[0], i[1] ^ i[2], 1'b0, 0, "R4 first frame");
    endtask

    task automatic t_block_out();
        blk_dir = 1'b1;
        for (int i = 0; i < 400; i++) sub(i[1], i[0], 1'b0, 0, "R4 block marker");
    endtask

    task automatic t_force();
        blk_dir = 1'b1;
        if (lrck) sub(0, 0, 0, 0, "R4 align");
        sub(0, 0, 0, 3, "R8 pulse while output");
        sub(1, 0, 0, 0, "R8 pulse ignored");
        blk_dir = 1'b0;
        sub(0, 1, 0, 2, "R7 short pulse");
        sub(1, 1, 0, 0, "R7 short pulse ignored");
        sub(0, 0, 0, 3, "R6 qualified pulse");
        sub(1, 0, 0, 0, "R6 forced frame 0");
        for (int i = 0; i < 6; i++) sub(i[0], 0, 0, 0, "R6 count resumes");
        sub(0, 0, 0, 4, "R6 pulse on first half");
        sub(0, 1, 0, 0, "R6 forced on second half");
        for (int i = 0; i < 4; i++) sub(0, 0, 0, 0, "R6 count after second-half force");
    endtask

    task automatic t_mode_a();
        mode_b = 1'b0; blk_dir = 1'b0;
        for (int cmb = 0; cmb < 16; cmb++) begin
            copy_c = cmb[0]; orig = cmb[1]; emph_n = cmb[2]; audio = cmb[3];
            if (!lrck) sub(0, 0, 0, 0, "R4 align");
            sub(0, 0, 0, 3, "R6 force for sweep");
            for (int i = 0; i < 48; i++) sub(0, 0, 0, 0, "R10 R11 sweep marker");
        end
    endtask

    task automatic t_mode_b();
        mode_b = 1'b1; blk_dir = 1'b1;
        for (int i = 0; i < 24; i++) sub(i[2], i[0], i[0] ^ i[1] ^ i[3], 0, "R4 mode B marker");
        mode_b = 1'b0;
    endtask

    initial begin
        t_reset();
        t_vu();
        t_block_out();
        t_force();
        t_mode_a();
        t_mode_b();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(180000 * 5);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule